// File: doc/BRIEF.md
# PLL-Qualified Reset Sequencer

This block produces the internal system reset of a small microcontroller. It takes the active-low external reset pin and the lock flag of the clock PLL. The core is held in reset until two conditions are met: the pin has been released, and the PLL has reported lock without a break for a programmable qualification window. The window is 4096 clock cycles by default. Each lock dropout restarts the window. A loss of lock after release puts the core back into reset and qualification runs again from zero.

While reset is active, the block drives the reset defaults of the I/O ports. Every port is forced to input mode. The selected ports, ports 1 and 3 by default, also get their output latches preset to all ones. When reset ends, the block gives a one-cycle strobe that loads the program counter with the reset vector 0000h. It issues no write or clear to on-chip RAM, so memory contents survive a reset. A two-bit status output reports the phase of the sequence.

Top module: `rst_seq`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` is low and `seq_state` is 0 (waiting for pin). Both take effect at once, without waiting for a clock edge.
- R2: The pin and the lock flag each pass through two synchronizing flops. Suppose both are high before rising edge E. Then `seq_state` is still 0 after edge E+1 and becomes 1 after edge E+2. `sys_rst_n` rises synchronously at edge E+N+1, where N = `LOCK_CYCLES`.
- R3: While the pin is high and the lock flag is low, `sys_rst_n` stays low and `seq_state` is 1 (counting lock).
- R4: A lock dropout before release resets the count to zero. If lock returns before edge E, release happens at edge E+N+1. A dropout driven before edge E+N-1 of a run that began at E blocks the release that run would have reached at E+N+1.
- R5: While `sys_rst_n` is low, every bit of `port_in_mode` is 1, meaning the port is forced to input. While released, every bit is 0.
- R6: While `sys_rst_n` is low, `port_latch_set` equals `PRESET_MASK` (default 4'b1010, ports 1 and 3) and `port_latch_val` is all ones (FFh). While released, `port_latch_set` is 0.
- R7: `pc_load` is high for exactly the first cycle in which `sys_rst_n` is high. `pc_value` is 0000h.
- R8: If the lock flag falls before edge D while released, `sys_rst_n` is still high after edge D+1. It is low with `seq_state` 1 after edge D+2. A full new window of N edges is then required.
- R9: `seq_state` is 2 exactly when `sys_rst_n` is high. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pll_lock | input | 1 | PLL lock indicator, asynchronous |
| sys_rst_n | output | 1 | Internal system reset, active low |
| seq_state | output | 2 | 0 waiting for pin, 1 counting lock, 2 released |
| port_in_mode | output | NUM_PORTS | Per-port force-to-input during reset |
| port_latch_set | output | NUM_PORTS | Per-port latch preset during reset |
| port_latch_val | output | PORT_W | Value loaded by the latch preset (all ones) |
| pc_load | output | 1 | One-cycle program-counter load strobe at release |
| pc_value | output | PC_W | Reset vector for the program counter |

## Verification
The bench builds the block with `LOCK_CYCLES` set to 16 and keeps the default port count, port width and preset mask. A 16-cycle window lets one run cover several things: a complete qualification, a dropout placed right before the edge where release would land, a loss of lock after release, and several requalifications. The exact release edge can be checked in each case. The same counter and comparison logic scales to the 4096-cycle default, and only the counter width changes.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SQ_WAIT_PIN = 2'd0,
    SQ_COUNT    = 2'd1,
    SQ_RUN      = 2'd2
  } seq_state_t;

  // True when the current count is the final qualifying cycle of the window.
  function automatic logic qual_last(input int unsigned cnt, input int unsigned win);
    return cnt == win - 1;
  endfunction

  // Counter width needed to hold 0 .. win-1.
  function automatic int unsigned cnt_width(input int unsigned win);
    return (win > 2) ? $clog2(win) : 1;
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rst_seq_qual.sv
module rst_seq_qual
  import rst_seq_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pin_ok,
  input  logic       lock_ok,
  output seq_state_t state_o,
  output logic       released_o,
  output logic       release_evt_o
);

  localparam int unsigned CNT_W = cnt_width(LOCK_CYCLES);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rel_q;

  always_comb begin
    st_d          = st_q;
    cnt_d         = cnt_q;
    release_evt_o = 1'b0;
    if (!pin_ok) begin
      st_d  = SQ_WAIT_PIN;
      cnt_d = '0;
    end else if (!lock_ok) begin
      st_d  = SQ_COUNT;
      cnt_d = '0;
    end else if (st_q == SQ_RUN) begin
      st_d  = SQ_RUN;
      cnt_d = '0;
    end else if (qual_last(32'(cnt_q), LOCK_CYCLES)) begin
      st_d          = SQ_RUN;
      cnt_d         = '0;
      release_evt_o = 1'b1;
    end else begin
      st_d  = SQ_COUNT;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= SQ_WAIT_PIN;
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rel_q <= (st_d == SQ_RUN);
    end
  end

  assign state_o    = st_q;
  assign released_o = rel_q;

endmodule

// File: rtl/rst_seq_outs.sv
module rst_seq_outs #(
  parameter int unsigned          NUM_PORTS   = 4,
  parameter int unsigned          PORT_W      = 8,
  parameter int unsigned          PC_W        = 16,
  parameter logic [NUM_PORTS-1:0] PRESET_MASK = 4'b1010,
  parameter logic [PC_W-1:0]      RESET_VEC   = '0
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 released,
  input  logic                 release_evt,
  output logic [NUM_PORTS-1:0] port_in_mode,
  output logic [NUM_PORTS-1:0] port_latch_set,
  output logic [PORT_W-1:0]    port_latch_val,
  output logic                 pc_load,
  output logic [PC_W-1:0]      pc_value
);

  logic pc_load_q;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      assign port_in_mode[i] = ~released;
      if (PRESET_MASK[i]) begin : g_pre
        assign port_latch_set[i] = ~released;
      end else begin : g_keep
        assign port_latch_set[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pc_load_q <= 1'b0;
    else         pc_load_q <= release_evt;
  end

  assign port_latch_val = '1;
  assign pc_load        = pc_load_q;
  assign pc_value       = RESET_VEC;

endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned          LOCK_CYCLES = 4096,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter int unsigned          NUM_PORTS   = 4,
  parameter int unsigned          PORT_W      = 8,
  parameter int unsigned          PC_W        = 16,
  parameter logic [NUM_PORTS-1:0] PRESET_MASK = 4'b1010
) (
  input  logic                 clk,
  input  logic                 ext_rst_n,
  input  logic                 pll_lock,
  output logic                 sys_rst_n,
  output logic [1:0]           seq_state,
  output logic [NUM_PORTS-1:0] port_in_mode,
  output logic [NUM_PORTS-1:0] port_latch_set,
  output logic [PORT_W-1:0]    port_latch_val,
  output logic                 pc_load,
  output logic [PC_W-1:0]      pc_value
);

  // Named internal events, visible to the bound checker.
  logic       pin_ok;
  logic       lock_ok;
  logic       released;
  logic       release_evt;
  seq_state_t state;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .d      (1'b1),
    .q      (pin_ok)
  );

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .d      (pll_lock),
    .q      (lock_ok)
  );

  rst_seq_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_qual (
    .clk           (clk),
    .arst_n        (ext_rst_n),
    .pin_ok        (pin_ok),
    .lock_ok       (lock_ok),
    .state_o       (state),
    .released_o    (released),
    .release_evt_o (release_evt)
  );

  rst_seq_outs #(
    .NUM_PORTS   (NUM_PORTS),
    .PORT_W      (PORT_W),
    .PC_W        (PC_W),
    .PRESET_MASK (PRESET_MASK),
    .RESET_VEC   ('0)
  ) u_outs (
    .clk            (clk),
    .arst_n         (ext_rst_n),
    .released       (released),
    .release_evt    (release_evt),
    .port_in_mode   (port_in_mode),
    .port_latch_set (port_latch_set),
    .port_latch_val (port_latch_val),
    .pc_load        (pc_load),
    .pc_value       (pc_value)
  );

  assign sys_rst_n = released;
  assign seq_state = state;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned          LOCK_CYCLES = 4096,
  parameter int unsigned          NUM_PORTS   = 4,
  parameter logic [NUM_PORTS-1:0] PRESET_MASK = 4'b1010
) (
  input logic                 clk,
  input logic                 ext_rst_n,
  input logic                 pin_ok,
  input logic                 lock_ok,
  input logic                 sys_rst_n,
  input logic [1:0]           seq_state,
  input logic                 pc_load,
  input logic [NUM_PORTS-1:0] port_in_mode,
  input logic [NUM_PORTS-1:0] port_latch_set
);

  localparam int unsigned RUN_W = $clog2(LOCK_CYCLES + 1);

  // Independent count of consecutive qualifying edges, saturating at the window.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)              run_q <= '0;
    else if (pin_ok && lock_ok)  run_q <= (run_q == RUN_W'(LOCK_CYCLES)) ? run_q : run_q + 1'b1;
    else                         run_q <= '0;
  end

  a_r1_pin_forces_reset: assert property (@(posedge clk)
    !ext_rst_n |-> !sys_rst_n);

  a_r2_no_early_release: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) |-> (run_q >= RUN_W'(LOCK_CYCLES)));

  a_r8_lock_loss_reasserts: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !lock_ok |=> !sys_rst_n);

  a_r5_ports_input: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state != 2'd2) |-> (&port_in_mode));

  a_r5_ports_free: assert property (@(posedge clk) disable iff (!ext_rst_n)
    sys_rst_n |-> (port_in_mode == '0));

  a_r6_latch_preset: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state != 2'd2) |-> (port_latch_set == PRESET_MASK));

  a_r7_pc_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
    pc_load |=> !pc_load);

  a_r7_pc_on_release: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) |-> pc_load);

  a_r9_state_legal: assert property (@(posedge clk) disable iff (!ext_rst_n)
    seq_state != 2'd3);

  a_r9_state_matches: assert property (@(posedge clk) disable iff (!ext_rst_n)
    sys_rst_n == (seq_state == 2'd2));

endmodule

bind rst_seq rst_seq_chk #(
  .LOCK_CYCLES (LOCK_CYCLES),
  .NUM_PORTS   (NUM_PORTS),
  .PRESET_MASK (PRESET_MASK)
) u_chk (
  .clk            (clk),
  .ext_rst_n      (ext_rst_n),
  .pin_ok         (pin_ok),
  .lock_ok        (lock_ok),
  .sys_rst_n      (sys_rst_n),
  .seq_state      (seq_state),
  .pc_load        (pc_load),
  .port_in_mode   (port_in_mode),
  .port_latch_set (port_latch_set)
);

// File: tb/rst_seq_tb.sv
`timescale 1ns/1ps
module rst_seq_tb;

  localparam int N = 16;
  localparam logic [3:0] MASK = 4'b1010;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0;
  logic        pll_lock = 1'b0;
  logic        sys_rst_n;
  logic [1:0]  seq_state;
  logic [3:0]  port_in_mode;
  logic [3:0]  port_latch_set;
  logic [7:0]  port_latch_val;
  logic        pc_load;
  logic [15:0] pc_value;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  typedef struct {
    int          at;
    logic        rst;
    logic [1:0]  st;
    logic        pcl;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  rst_seq #(.LOCK_CYCLES(N)) u_dut (
    .clk            (clk),
    .ext_rst_n      (ext_rst_n),
    .pll_lock       (pll_lock),
    .sys_rst_n      (sys_rst_n),
    .seq_state      (seq_state),
    .port_in_mode   (port_in_mode),
    .port_latch_set (port_latch_set),
    .port_latch_val (port_latch_val),
    .pc_load        (pc_load),
    .pc_value       (pc_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Release edge for a run whose inputs were both high before edge e.
  function automatic int rel_edge(input int e);
    return e + 2 + (N - 1);
  endfunction

  task automatic push(input int at, input logic rst, input logic [1:0] st,
                      input logic pcl, input string req);
    exp_t it;
    it.at = at; it.rst = rst; it.st = st; it.pcl = pcl; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops scoreboard entries at their cycle, sampling at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t it;
        it = sb.pop_front();
        if (it.at < cyc) begin
          check({it.req, " missed slot"}, 32'(cyc), 32'(it.at));
        end else begin
          check({it.req, " sys_rst_n"}, 32'(sys_rst_n), 32'(it.rst));
          check({it.req, " seq_state"}, 32'(seq_state), 32'(it.st));
          check({it.req, " pc_load"},   32'(pc_load),   32'(it.pcl));
          check({it.req, " R5 port_in_mode"},   32'(port_in_mode),   it.rst ? 32'h0 : 32'hF);
          check({it.req, " R6 port_latch_set"}, 32'(port_latch_set), it.rst ? 32'h0 : 32'(MASK));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e;
    int e2;
    int d;

    // Reset state with the pin low.
    repeat (3) @(negedge clk);
    check("R1 sys_rst_n low", 32'(sys_rst_n), 32'h0);
    check("R1 state wait",    32'(seq_state), 32'h0);
    check("R5 inputs forced", 32'(port_in_mode), 32'hF);
    check("R6 preset mask",   32'(port_latch_set), 32'(MASK));
    check("R6 latch value",   32'(port_latch_val), 32'hFF);
    check("R7 pc value",      32'(pc_value), 32'h0);
    check("R7 no strobe",     32'(pc_load), 32'h0);

    // R2 / R7: lock already up, pin released.
    pll_lock = 1'b1;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    e = cyc + 1;
    push(e + 1, 1'b0, 2'd0, 1'b0, "R2 sync latency");
    push(e + 2, 1'b0, 2'd1, 1'b0, "R2 counting");
    push(rel_edge(e) - 1, 1'b0, 2'd1, 1'b0, "R2 not yet");
    push(rel_edge(e),     1'b1, 2'd2, 1'b1, "R2 R7 release");
    push(rel_edge(e) + 1, 1'b1, 2'd2, 1'b0, "R7 strobe ends");
    wait_until(rel_edge(e) + 3);

    // R8: loss of lock after release.
    pll_lock = 1'b0;
    d = cyc + 1;
    push(d + 1, 1'b1, 2'd2, 1'b0, "R8 still out");
    push(d + 2, 1'b0, 2'd1, 1'b0, "R8 reasserted");
    wait_until(d + 4);
    pll_lock = 1'b1;
    e = cyc + 1;
    push(rel_edge(e) - 1, 1'b0, 2'd1, 1'b0, "R8 full window");
    push(rel_edge(e),     1'b1, 2'd2, 1'b1, "R8 requalified");
    wait_until(rel_edge(e) + 3);

    // R1: pin low takes effect before any edge.
    ext_rst_n = 1'b0;
    pll_lock  = 1'b0;
    #1;
    check("R1 async assert", 32'(sys_rst_n), 32'h0);
    check("R1 async state",  32'(seq_state), 32'h0);
    check("R5 async inputs", 32'(port_in_mode), 32'hF);
    @(negedge clk);

    // R3: pin up, lock down, reset holds.
    ext_rst_n = 1'b1;
    e = cyc + 1;
    push(e + 5,  1'b0, 2'd1, 1'b0, "R3 hold a");
    push(e + 20, 1'b0, 2'd1, 1'b0, "R3 hold b");
    push(e + 40, 1'b0, 2'd1, 1'b0, "R3 hold c");
    wait_until(e + 42);

    // R4: dropout just before the release edge.
    pll_lock = 1'b1;
    e = cyc + 1;
    wait_until(e + N - 2);
    pll_lock = 1'b0;
    push(rel_edge(e),     1'b0, 2'd1, 1'b0, "R4 release blocked");
    push(rel_edge(e) + 1, 1'b0, 2'd1, 1'b0, "R4 still counting");
    wait_until(cyc + 3);
    pll_lock = 1'b1;
    e2 = cyc + 1;
    push(rel_edge(e2) - 1, 1'b0, 2'd1, 1'b0, "R4 restart window");
    push(rel_edge(e2),     1'b1, 2'd2, 1'b1, "R4 release after restart");
    push(rel_edge(e2) + 1, 1'b1, 2'd2, 1'b0, "R9 run state");
    wait_until(rel_edge(e2) + 3);

    // R1 from the released state.
    ext_rst_n = 1'b0;
    #1;
    check("R1 async from run", 32'(sys_rst_n), 32'h0);
    check("R9 state wait",     32'(seq_state), 32'h0);
    check("R6 preset again",   32'(port_latch_set), 32'(MASK));
    repeat (3) @(negedge clk);

    if (sb.size() != 0) check("scoreboard drained", 32'(sb.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule